// File: doc/BRIEF.md
# Error-Triggered Event Capture Controller

This block keeps track of which built events go into a 128-slot monitor buffer. It holds no event data. It drives the slot write pointer and keeps the slot occupancy, the full flag, a pause request to the event builder, a sticky record of the error classes it has seen, and the number of events taken after a trigger. Each event reports its end with a single strobe and an 8-bit error vector. A configuration write loads an 8-bit trigger mask and a 16-bit prescale, and the same write re-arms the block.

The mask selects one of two modes.

- **Prescaled mode (mask all zero):** one event in every prescale+1 is kept. Keeping stops when all slots are occupied. The host frees slots one at a time with a read-done strobe.
- **Triggered mode (mask nonzero):** every event is kept and the buffer runs as a ring that overwrites its oldest slot. An event whose error bits hit the mask is the trigger. After it, a fixed number of further events are captured and then the buffer freezes, so the events before and after the fault are both kept.

Top module: `mon_capture_ctrl`

## Requirements
- R1: Out of reset, every output is 0: write pointer, occupancy, post-trigger count, error record, full, pause and wrapped.
- R2: With a zero mask, the first event after a configuration write is kept. After that, one event in every prescale+1 events is kept. Each kept event advances the write pointer by one, modulo 128.
- R3: With a zero mask, occupancy stops at 128. At 128, full_o is 1 and further events are not kept. A read-done strobe that brings occupancy below 128 clears full_o.
- R4: With a nonzero mask, every event is kept, occupancy saturates at 128 and the pointer keeps wrapping. wrapped_o is set once occupancy has reached 128 and stays set until the next configuration write.
- R5: With a nonzero mask, the first kept event with (err & mask) != 0 is the trigger. The trigger is kept but is not counted. Each later kept event increments post_cnt_o. When post_cnt_o reaches 64, the capture freezes and full_o becomes 1.
- R6: Once frozen, events are not kept, even when they carry trigger errors. The write pointer and post_cnt_o hold.
- R7: Mask and error bit meanings:
  - bit 7: overlong event, truncated past 512 words
  - bit 6: CRC error
  - bit 5: orbit or bunch-crossing mismatch
  - bit 4: event-number mismatch
  - bits 3..0: four channel status flags

  Error bits outside the mask never trigger. err_rec_o is the sticky OR of (err & mask) over kept events.
- R8: A configuration write loads the mask and prescale. It clears pointer, occupancy, post count, error record, wrapped and freeze, and re-arms the block. An event in the same cycle as the write is dropped.
- R9: pause_o is 1 exactly when pause_en_i is 1 and full_o is 1.
- R10: rd_done_i lowers occupancy by one, but never below 0. A kept event and a read-done strobe in the same cycle leave occupancy unchanged.
- R11: While run_i is 0, events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; events are ignored while low |
| evt_end_i | input | 1 | End-of-event strobe |
| evt_err_i | input | 8 | Error vector of the ending event |
| cfg_we_i | input | 1 | Configuration write and re-arm |
| cfg_mask_i | input | 8 | Trigger mask; zero selects prescaled mode |
| cfg_prescale_i | input | 16 | Keep one event in prescale+1 |
| pause_en_i | input | 1 | Allow a full buffer to pause the builder |
| rd_done_i | input | 1 | Host has read one slot |
| wr_ptr_o | output | 7 | Next slot to be written |
| full_o | output | 1 | Buffer full or capture frozen |
| pause_o | output | 1 | Pause request to event builder |
| err_rec_o | output | 8 | Sticky masked error record |
| post_cnt_o | output | 8 | Events kept after the trigger |
| stored_cnt_o | output | 8 | Occupied slots, 0..128 |
| wrapped_o | output | 1 | 128 events have been stored |

## Verification
Two pairs of operations can fall in the same cycle: a configuration write with an event end, and a kept event with a read-done strobe. The bench drives each pair on one clock edge.

- **Write with event:** judged by an occupancy and pointer of zero afterwards, which shows the event was dropped.
- **Event with read-done:** judged by unchanged occupancy while the pointer still advances.

The trigger path is also driven with events whose errors lie outside the mask, and with triggers sent after the freeze.

// File: rtl/mon_capture_pkg.sv
package mon_capture_pkg;
  typedef enum logic [1:0] {
    CAP_ARMED  = 2'd0,
    CAP_POST   = 2'd1,
    CAP_FROZEN = 2'd2
  } cap_state_e;
endpackage

// File: rtl/mon_psc.sv
module mon_psc #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] load_i,
  output logic             hit_o
);
  logic [PSC_W-1:0] cnt_q;

  assign hit_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= hit_o ? load_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/mon_slot_track.sv
module mon_slot_track #(
  parameter int SLOTS = 128,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             keep_i,
  input  logic             rel_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [CNT_W-1:0] stored_o,
  output logic             wrapped_o
);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(SLOTS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, dec, inc;

  // release only when a slot is occupied; ring overwrite keeps count at top
  assign dec = rel_i && (cnt_q != '0);
  assign inc = keep_i && ((cnt_q != SLOTS_C) || dec);

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (keep_i) ptr_q <= (ptr_q == LAST_C) ? '0 : ptr_q + 1'b1;
      if (cnt_d == SLOTS_C) wrap_q <= 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign stored_o  = cnt_q;
  assign wrapped_o = wrap_q;
endmodule

// File: rtl/mon_trig_seq.sv
module mon_trig_seq
  import mon_capture_pkg::*;
#(
  parameter int POST_EVENTS = 64,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ev_i,
  input  logic             hit_i,
  output logic             frozen_o,
  output logic [CNT_W-1:0] post_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(POST_EVENTS - 1);

  cap_state_e       st_q;
  logic [CNT_W-1:0] post_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAP_ARMED;
      post_q <= '0;
    end else if (clr_i) begin
      st_q   <= CAP_ARMED;
      post_q <= '0;
    end else if (ev_i) begin
      unique case (st_q)
        CAP_ARMED: if (hit_i) st_q <= CAP_POST;
        CAP_POST: begin
          post_q <= post_q + 1'b1;
          if (post_q == LAST_C) st_q <= CAP_FROZEN;
        end
        default: ;
      endcase
    end
  end

  assign frozen_o = (st_q == CAP_FROZEN);
  assign post_o   = post_q;
endmodule

// File: rtl/mon_capture_ctrl.sv
module mon_capture_ctrl #(
  parameter int SLOTS       = 128,
  parameter int POST_EVENTS = 64,
  parameter int ERR_W       = 8,
  parameter int PSC_W       = 16,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             evt_end_i,
  input  logic [ERR_W-1:0] evt_err_i,
  input  logic             cfg_we_i,
  input  logic [ERR_W-1:0] cfg_mask_i,
  input  logic [PSC_W-1:0] cfg_prescale_i,
  input  logic             pause_en_i,
  input  logic             rd_done_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             full_o,
  output logic             pause_o,
  output logic [ERR_W-1:0] err_rec_o,
  output logic [CNT_W-1:0] post_cnt_o,
  output logic [CNT_W-1:0] stored_cnt_o,
  output logic             wrapped_o
);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  logic [ERR_W-1:0] mask_q, rec_q;
  logic [PSC_W-1:0] psc_q;
  logic             trig_mode, evt_ok, slots_full, psc_tick, psc_hit;
  logic             keep, hit, frozen, rel;
  logic [CNT_W-1:0] stored;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      psc_q  <= '0;
      rec_q  <= '0;
    end else if (cfg_we_i) begin
      mask_q <= cfg_mask_i;
      psc_q  <= cfg_prescale_i;
      rec_q  <= '0;
    end else if (keep) begin
      rec_q  <= rec_q | (evt_err_i & mask_q);
    end
  end

  assign trig_mode  = |mask_q;
  assign evt_ok     = evt_end_i && run_i && !cfg_we_i;
  assign slots_full = (stored == SLOTS_C);
  assign psc_tick   = evt_ok && !trig_mode && !slots_full;
  assign hit        = |(evt_err_i & mask_q);
  assign keep       = trig_mode ? (evt_ok && !frozen) : (psc_tick && psc_hit);
  assign rel        = rd_done_i && !cfg_we_i;

  mon_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .tick_i (psc_tick),
    .load_i (psc_q),
    .hit_o  (psc_hit)
  );

  mon_slot_track #(.SLOTS(SLOTS)) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_we_i),
    .keep_i    (keep),
    .rel_i     (rel),
    .ptr_o     (wr_ptr_o),
    .stored_o  (stored),
    .wrapped_o (wrapped_o)
  );

  mon_trig_seq #(.POST_EVENTS(POST_EVENTS), .CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_we_i),
    .ev_i     (keep && trig_mode),
    .hit_i    (hit),
    .frozen_o (frozen),
    .post_o   (post_cnt_o)
  );

  assign full_o       = trig_mode ? frozen : slots_full;
  assign pause_o      = pause_en_i && full_o;
  assign err_rec_o    = rec_q;
  assign stored_cnt_o = stored;
endmodule

// File: rtl/mon_capture_ctrl_chk.sv
module mon_capture_ctrl_chk #(
  parameter int SLOTS       = 128,
  parameter int POST_EVENTS = 64,
  parameter int ERR_W       = 8,
  parameter int PSC_W       = 16,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             evt_end_i,
  input logic             cfg_we_i,
  input logic             pause_en_i,
  input logic             rd_done_i,
  input logic [PTR_W-1:0] wr_ptr_o,
  input logic             full_o,
  input logic             pause_o,
  input logic [CNT_W-1:0] post_cnt_o,
  input logic [CNT_W-1:0] stored_cnt_o
);
  a_r3_stored_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stored_cnt_o <= CNT_W'(SLOTS));

  a_r5_post_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_cnt_o <= CNT_W'(POST_EVENTS));

  a_r6_full_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !cfg_we_i) |=> $stable(wr_ptr_o));

  a_r8_rearm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (stored_cnt_o == '0 && post_cnt_o == '0 && wr_ptr_o == '0 && !full_o));

  a_r9_pause_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> (full_o && pause_en_i));

  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_cnt_o == '0 && !evt_end_i) |=> stored_cnt_o == '0);

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !rd_done_i && !cfg_we_i) |=> ($stable(stored_cnt_o) && $stable(wr_ptr_o)));
endmodule

bind mon_capture_ctrl mon_capture_ctrl_chk #(
  .SLOTS(SLOTS), .POST_EVENTS(POST_EVENTS), .ERR_W(ERR_W), .PSC_W(PSC_W)
) u_chk (.*);

// File: tb/mon_capture_ctrl_bench.sv
`timescale 1ns/1ps
module mon_capture_ctrl_bench;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       run, evt_end, cfg_we, pause_en, rd_done;
  logic [7:0] evt_err, cfg_mask;
  logic [15:0] cfg_psc;
  logic [6:0] wr_ptr;
  logic       full, pause, wrapped;
  logic [7:0] err_rec, post_cnt, stored;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mon_capture_ctrl u_mon_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .evt_end_i(evt_end), .evt_err_i(evt_err),
    .cfg_we_i(cfg_we), .cfg_mask_i(cfg_mask), .cfg_prescale_i(cfg_psc),
    .pause_en_i(pause_en), .rd_done_i(rd_done),
    .wr_ptr_o(wr_ptr), .full_o(full), .pause_o(pause), .err_rec_o(err_rec),
    .post_cnt_o(post_cnt), .stored_cnt_o(stored), .wrapped_o(wrapped)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] m, input logic [15:0] p);
    @(negedge clk); cfg_we = 1'b1; cfg_mask = m; cfg_psc = p;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] e);
    @(negedge clk); evt_end = 1'b1; evt_err = e;
    repeat (n) @(negedge clk);
    evt_end = 1'b0; evt_err = '0;
  endtask

  // {prescale, events, expected occupancy}
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{0, 10, 10}, '{2, 10, 4}, '{4, 12, 3}, '{1, 7, 4}, '{0, 130, 128}
  };

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run = 1'b1; evt_end = 0; cfg_we = 0; pause_en = 0; rd_done = 0;
    evt_err = '0; cfg_mask = '0; cfg_psc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", wr_ptr, 0); chk("R1 stored", stored, 0); chk("R1 full", full, 0);
    chk("R1 pause", pause, 0); chk("R1 rec", err_rec, 0); chk("R1 post", post_cnt, 0);
    chk("R1 wrapped", wrapped, 0);
    rst_ni = 1'b1;

    // R2/R3 prescale table
    for (int i = 0; i < NV; i++) begin
      cfg(8'h00, 16'(VEC[i][0]));
      send(VEC[i][1], 8'h00);
      chk("R2 stored", stored, VEC[i][2]);
      chk("R2 ptr", wr_ptr, VEC[i][2] % 128);
    end
    chk("R3 full at 128", full, 1);
    send(3, 8'h00);
    chk("R3 no keep when full", stored, 128);
    chk("R9 pause off", pause, 0);
    pause_en = 1'b1; @(negedge clk);
    chk("R9 pause on", pause, 1);
    pause_en = 1'b0;
    @(negedge clk); rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
    chk("R10 release", stored, 127);
    chk("R3 full clears", full, 0);

    // R10 underflow guard, same-cycle keep+release
    cfg(8'h00, 16'd0);
    @(negedge clk); rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
    chk("R10 floor", stored, 0);
    send(5, 8'h00);
    @(negedge clk); evt_end = 1'b1; rd_done = 1'b1;
    @(negedge clk); evt_end = 1'b0; rd_done = 1'b0;
    chk("R10 net zero", stored, 5);
    chk("R10 ptr moves", wr_ptr, 6);

    // R8 write wins over event
    @(negedge clk); cfg_we = 1'b1; cfg_mask = 8'h00; cfg_psc = 16'd0; evt_end = 1'b1;
    @(negedge clk); cfg_we = 1'b0; evt_end = 1'b0;
    chk("R8 event dropped", stored, 0);
    chk("R8 ptr cleared", wr_ptr, 0);

    // R11 run low
    run = 1'b0; send(4, 8'h00); run = 1'b1;
    chk("R11 ignored", stored, 0);

    // R4..R7 triggered mode, mask bit6 = CRC
    cfg(8'h40, 16'd0);
    send(200, 8'h00);
    chk("R4 stored sat", stored, 128);
    chk("R4 wrapped", wrapped, 1);
    chk("R4 ptr", wr_ptr, 72);
    chk("R4 not full", full, 0);
    send(1, 8'h01);
    chk("R7 unmasked no trig", post_cnt, 0);
    chk("R7 unmasked not recorded", err_rec, 0);
    send(1, 8'h41);
    chk("R5 trigger not counted", post_cnt, 0);
    chk("R7 masked recorded", err_rec, 8'h40);
    send(63, 8'h00);
    chk("R5 post 63", post_cnt, 63);
    chk("R5 not yet full", full, 0);
    send(1, 8'h00);
    chk("R5 post 64", post_cnt, 64);
    chk("R5 full", full, 1);
    chk("R5 ptr", wr_ptr, 10);
    send(5, 8'h40);
    chk("R6 ptr frozen", wr_ptr, 10);
    chk("R6 post frozen", post_cnt, 64);

    // R8 re-arm clears
    cfg(8'h10, 16'd0);
    chk("R8 full clr", full, 0); chk("R8 post clr", post_cnt, 0);
    chk("R8 rec clr", err_rec, 0); chk("R8 wrapped clr", wrapped, 0);
    send(3, 8'h00); send(1, 8'h10); send(10, 8'h00);
    run = 1'b0; send(6, 8'h00); run = 1'b1;
    chk("R11 early stop post", post_cnt, 10);
    chk("R5 early not full", full, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule